// File: doc/BRIEF.md
# Command-Framed SPI Scratch RAM Port

This block is a SPI slave that gives an external master byte access to a 31-entry scratch RAM and a small register space. The link runs in SPI mode 3: SCLK idles high, the slave samples DIN on each rising edge and changes its output on each falling edge. Every byte travels most significant bit first. A transaction starts when chip select goes low. The first byte is a command that picks the direction, the space and a five-bit address. Any number of data bytes follows while chip select stays low. After each data byte the address steps forward, so one transaction can move a whole block of data.

A control register in register space holds a write-protect flag. While the flag is set, the RAM ignores every write from the bus. The serial output is enabled only while read data is being returned. The rest of the time the block holds its output-enable low, so the line can be shared with other slaves.

All pins are sampled by one fast system clock through synchronizers. That clock must run at least four times faster than SCLK.

Top module: `spi_ram_slave`

## Requirements
- R1: Input bits are taken on SCLK rising edges, MSB first. Read data changes only after SCLK falling edges and stays stable across the following rising edge, MSB first.
- R2: In the command byte, bit 7 set to 1 means read and 0 means write. Bit 6 set to 1 selects RAM and 0 selects register space. Bits 5..1 carry the start address. Bit 0 is sent as 1 but is not decoded, so a command with bit 0 clear behaves the same way.
- R3: The RAM holds 31 bytes at addresses 0 to 30. All of them read 0x00 after reset, and a byte written to an address reads back unchanged.
- R4: Within one transaction the address advances by one after every data byte. In RAM space it wraps from 30, and from 31, back to 0. In register space it counts modulo 32.
- R5: RAM-space address 31 always reads 0x00, and writes to it are ignored.
- R6: The control register sits at register-space address 15, resets to 0x00, and reads back what was written to it. Every other register-space address reads 0x00 and ignores writes.
- R7: While bit 7 of the control register is 1, writes to RAM are ignored. The control register itself stays writable.
- R8: The output enable is low during the command byte and during any write transaction. It goes high at the first SCLK falling edge after a read command and drops within three system clocks of the synchronized chip-select rise.
- R9: When chip select rises partway through a byte, that partial byte is discarded and writes nothing. Data bytes completed earlier in the same transaction remain written.
- R10: After chip select has been high, the next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the master, idle high |
| csNIn | input | 1 | Active-low chip select from the master |
| dinIn | input | 1 | Serial data from the master |
| doutOut | output | 1 | Serial read data to the master |
| doutEn | output | 1 | Output enable for doutOut; low means high impedance |

## Verification
The assertions assume that SCLK, chip select and DIN change slowly compared with the system clock. Each level must be held for several system clocks, so that every edge survives the synchronizers as one clean transition. They also assume that the master lowers chip select a few clocks before the first SCLK fall. The bench keeps to this: it holds each SCLK phase for eight system clocks, changes DIN only while SCLK is low, and leaves eight clocks of setup and hold around every chip-select edge. Random transactions of mixed direction, space, address and burst length are mixed with directed cases for wrap, address 31, write protect and aborted bytes.

// File: rtl/spi_ram_pkg.sv
`timescale 1ns/1ps
package spi_ram_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_CMD,
    XF_DATA
  } xferState_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic              sampleBit;  // shift DIN into the receive register
    logic              writeByte;  // a full write data byte is ready
    logic              loadTx;     // fetch the next read byte
    logic              shiftOut;   // present the next read bit
    logic              endXfer;    // chip select is inactive
    logic              isRam;      // space of the access
    logic [ADDR_W-1:0] addr;       // address of the access
  } dpStrobe_t;
endpackage

// File: rtl/spi_ram_ctrl.sv
`timescale 1ns/1ps
module spi_ram_ctrl
  import spi_ram_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              dinIn,
  input  logic [DATA_W-1:1] cmdBits,
  output logic              dinSync,
  output dpStrobe_t         strobe,
  output logic              rdMode
);
  localparam int                NUM_SYNC = 3;
  localparam logic [NUM_SYNC-1:0] SYNC_RST = 3'b110;  // sclk high, cs high, din low
  localparam int                CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] LAST_RAM = ADDR_W'(RAM_DEPTH - 1);

  logic [NUM_SYNC-1:0] syncIn;
  logic [NUM_SYNC-1:0] syncOut;
  assign syncIn = {sclkIn, csNIn, dinIn};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{SYNC_RST[g]}};
      else       chain <= {chain[SYNC_STAGES-2:0], syncIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  logic sclkS, csS;
  assign sclkS   = syncOut[2];
  assign csS     = syncOut[1];
  assign dinSync = syncOut[0];

  logic sclkPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkS;
  end

  logic sclkRise, sclkFall, active;
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign active   = ~csS;

  xferState_t        state;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] curAddr;
  logic              curRam, curRead;

  logic              cmdRead, cmdRam;
  logic [ADDR_W-1:0] cmdAddr;
  assign cmdRead = cmdBits[DATA_W-1];
  assign cmdRam  = cmdBits[DATA_W-2];
  assign cmdAddr = cmdBits[ADDR_W:1];

  function automatic logic [ADDR_W-1:0] advance(input logic ram, input logic [ADDR_W-1:0] a);
    if (ram) return (a >= LAST_RAM) ? '0 : a + 1'b1;
    return a + 1'b1;
  endfunction

  logic inFrame, byteDone;
  assign inFrame  = active && (state != XF_IDLE);
  assign byteDone = inFrame && sclkRise && (bitCnt == LAST_BIT);

  always_comb begin
    strobe           = '0;
    strobe.sampleBit = inFrame && sclkRise;
    strobe.endXfer   = !active;
    strobe.writeByte = byteDone && (state == XF_DATA) && !curRead;
    strobe.loadTx    = byteDone && (((state == XF_CMD) && cmdRead) ||
                                    ((state == XF_DATA) && curRead));
    strobe.shiftOut  = inFrame && sclkFall && (state == XF_DATA) && curRead;
    if (state == XF_CMD) begin
      strobe.isRam = cmdRam;
      strobe.addr  = cmdAddr;
    end else begin
      strobe.isRam = curRam;
      strobe.addr  = curRead ? advance(curRam, curAddr) : curAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= XF_IDLE;
      bitCnt  <= '0;
      curAddr <= '0;
      curRam  <= 1'b0;
      curRead <= 1'b0;
    end else if (!active) begin
      state   <= XF_IDLE;
      bitCnt  <= '0;
      curRead <= 1'b0;
    end else begin
      case (state)
        XF_IDLE: begin
          state  <= XF_CMD;
          bitCnt <= '0;
        end
        XF_CMD: begin
          if (sclkRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            state   <= XF_DATA;
            curAddr <= cmdAddr;
            curRam  <= cmdRam;
            curRead <= cmdRead;
          end
        end
        XF_DATA: begin
          if (sclkRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) curAddr <= advance(curRam, curAddr);
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assign rdMode = (state == XF_DATA) && curRead;

  // R9
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0) && (state == XF_IDLE));

  // R4
  ram_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && (state == XF_DATA) && curRam) |=> (curAddr <= LAST_RAM));

  // R2
  cmd_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && (state == XF_CMD)) |=>
      (curRead == $past(cmdBits[DATA_W-1])) && (curRam == $past(cmdBits[DATA_W-2])));
endmodule

// File: rtl/spi_ram_dp.sv
`timescale 1ns/1ps
module spi_ram_dp
  import spi_ram_pkg::*;
#(
  parameter int RAM_DEPTH = 31,
  parameter int CTRL_ADDR = 15,
  parameter int WP_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinSync,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] rxByte,
  output logic              doutOut,
  output logic              doutEn
);
  localparam logic [ADDR_W-1:0] RAM_END  = ADDR_W'(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);

  logic [DATA_W-1:0]                rxShift;
  logic [RAM_DEPTH-1:0][DATA_W-1:0] ramQ;
  logic [DATA_W-1:0]                ctrlQ;
  logic [DATA_W-1:0]                txShift;

  assign rxByte = {rxShift[DATA_W-2:0], dinSync};

  logic              writeProt, ramHit, ctrlHit, ramWe, ctrlWe;
  logic [ADDR_W-1:0] ramIdx;
  logic [DATA_W-1:0] rdData;

  assign writeProt = ctrlQ[WP_BIT];
  assign ramHit    = strobe.addr < RAM_END;
  assign ctrlHit   = strobe.addr == CTRL_SEL;
  assign ramIdx    = ramHit ? strobe.addr : '0;
  assign ramWe     = strobe.writeByte && strobe.isRam && ramHit && !writeProt;
  assign ctrlWe    = strobe.writeByte && !strobe.isRam && ctrlHit;

  always_comb begin
    if (strobe.isRam) rdData = ramHit ? ramQ[ramIdx] : '0;
    else              rdData = ctrlHit ? ctrlQ : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxShift <= '0;
    else if (strobe.endXfer)   rxShift <= '0;
    else if (strobe.sampleBit) rxShift <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramQ <= '0;
    end else if (ramWe) begin
      for (int w = 0; w < RAM_DEPTH; w++) begin
        if (ramIdx == ADDR_W'(w)) ramQ[w] <= rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      doutOut <= 1'b0;
      doutEn  <= 1'b0;
    end else if (strobe.endXfer) begin
      txShift <= '0;
      doutOut <= 1'b0;
      doutEn  <= 1'b0;
    end else if (strobe.loadTx) begin
      txShift <= rdData;
    end else if (strobe.shiftOut) begin
      doutOut <= txShift[DATA_W-1];
      txShift <= {txShift[DATA_W-2:0], 1'b0};
      doutEn  <= 1'b1;
    end
  end

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeByte && strobe.isRam && writeProt) |=> $stable(ramQ));

  // R5
  ram_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeByte && strobe.isRam && (strobe.addr >= RAM_END)) |=> $stable(ramQ));

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endXfer |=> !doutEn);

  // R6
  unmapped_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && !strobe.isRam && (strobe.addr != CTRL_SEL)) |=> (txShift == '0));
endmodule

// File: rtl/spi_ram_slave.sv
`timescale 1ns/1ps
module spi_ram_slave
  import spi_ram_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 31,
  parameter int CTRL_ADDR   = 15,
  parameter int WP_BIT      = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dinIn,
  output logic doutOut,
  output logic doutEn
);
  dpStrobe_t         strobe;
  logic              dinSync;
  logic              rdMode;
  logic [DATA_W-1:0] rxByte;

  spi_ram_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .RAM_DEPTH  (RAM_DEPTH)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclkIn),
    .csNIn  (csNIn),
    .dinIn  (dinIn),
    .cmdBits(rxByte[DATA_W-1:1]),
    .dinSync(dinSync),
    .strobe (strobe),
    .rdMode (rdMode)
  );

  spi_ram_dp #(
    .RAM_DEPTH(RAM_DEPTH),
    .CTRL_ADDR(CTRL_ADDR),
    .WP_BIT   (WP_BIT)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .dinSync(dinSync),
    .strobe (strobe),
    .rxByte (rxByte),
    .doutOut(doutOut),
    .doutEn (doutEn)
  );

  // R8
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    doutEn |-> rdMode);
endmodule

// File: tb/spi_ram_slave_tb.sv
`timescale 1ns/1ps
module spi_ram_slave_tb_top;
  localparam int HALF = 8;  // system clocks per SCLK phase

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1;
  logic csN = 1'b1;
  logic din = 1'b0;
  logic dout, doutEn;

  always #2.5 clk = ~clk;

  spi_ram_slave dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclk),
    .csNIn  (csN),
    .dinIn  (din),
    .doutOut(dout),
    .doutEn (doutEn)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] frame [0:39];
  logic [7:0] got   [0:39];
  logic sawOeCmd, sawOeWrite, holdErr;
  logic [7:0] mRam [0:31];
  logic [7:0] mCtrl;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkCmd(input bit rd, input bit ram, input int a, input bit lsb);
    logic [4:0] a5;
    a5 = a[4:0];
    return {rd, ram, a5, lsb};
  endfunction

  function automatic int nxt(input bit ram, input int a);
    if (ram) return (a >= 30) ? 0 : a + 1;
    return (a + 1) % 32;
  endfunction

  function automatic logic [7:0] mRead(input bit ram, input int a);
    if (ram) return (a == 31) ? 8'h00 : mRam[a];
    return (a == 15) ? mCtrl : 8'h00;
  endfunction

  task automatic mWrite(input bit ram, input int a, input logic [7:0] d);
    if (ram) begin
      if (a != 31 && !mCtrl[7]) mRam[a] = d;
    end else if (a == 15) begin
      mCtrl = d;
    end
  endtask

  task automatic runFrame(input int nb, input int cutBits);
    int total;
    total = (cutBits > 0) ? (nb - 1) * 8 + cutBits : nb * 8;
    sawOeCmd = 1'b0; sawOeWrite = 1'b0; holdErr = 1'b0;
    csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      int b;
      int k;
      logic pre;
      b = i / 8;
      k = 7 - (i % 8);
      sclk = 1'b0;
      din = frame[b][k];
      repeat (HALF) @(negedge clk);
      pre = dout;
      got[b][k] = pre;
      if (b == 0 && doutEn) sawOeCmd = 1'b1;
      if (!frame[0][7] && doutEn) sawOeWrite = 1'b1;
      sclk = 1'b1;
      repeat (HALF / 2) @(negedge clk);
      if (frame[0][7] && b > 0 && dout !== pre) holdErr = 1'b1;
      repeat (HALF - HALF / 2) @(negedge clk);
    end
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic doWrite(input bit ram, input int a, input int n);
    int ad;
    ad = a;
    frame[0] = mkCmd(1'b0, ram, a, 1'b1);
    runFrame(n + 1, 0);
    chk("R8 oe during write", {7'd0, sawOeWrite}, 8'h00);
    for (int i = 1; i <= n; i++) begin
      mWrite(ram, ad, frame[i]);
      ad = nxt(ram, ad);
    end
  endtask

  task automatic doRead(input bit ram, input int a, input int n, input string req);
    int ad;
    ad = a;
    frame[0] = mkCmd(1'b1, ram, a, 1'b1);
    for (int i = 1; i <= n; i++) frame[i] = 8'h00;
    runFrame(n + 1, 0);
    chk("R8 oe during command", {7'd0, sawOeCmd}, 8'h00);
    chk("R1 read bit held over rise", {7'd0, holdErr}, 8'h00);
    for (int i = 1; i <= n; i++) begin
      chk(req, got[i], mRead(ram, ad));
      ad = nxt(ram, ad);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit rd;
    bit ram;
    int a;
    int n;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 32; i++) mRam[i] = 8'h00;
    mCtrl = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R8 oe low after reset", {7'd0, doutEn}, 8'h00);
    doRead(1'b0, 15, 1, "R6 control reset value");
    doRead(1'b1, 0, 3, "R3 RAM reset value");

    // burst write across the wrap point, then burst read back
    frame[1] = 8'h81; frame[2] = 8'h5A; frame[3] = 8'hC3; frame[4] = 8'h7E; frame[5] = 8'h01;
    doWrite(1'b1, 28, 5);
    doRead(1'b1, 28, 5, "R4 burst wrap read");
    doRead(1'b1, 0, 2, "R3 single read after wrap write");

    // address 31
    frame[1] = 8'hAA;
    doWrite(1'b1, 31, 1);
    doRead(1'b1, 31, 3, "R5 address 31 reads zero then wraps");

    // command bit 0 not decoded
    frame[0] = mkCmd(1'b1, 1'b1, 29, 1'b0);
    frame[1] = 8'h00;
    runFrame(2, 0);
    chk("R2 bit0 clear still reads", got[1], mRead(1'b1, 29));

    // register space
    frame[1] = 8'h55;
    doWrite(1'b0, 3, 1);
    doRead(1'b0, 3, 1, "R6 unmapped register reads zero");
    frame[1] = 8'h80;
    doWrite(1'b0, 15, 1);
    doRead(1'b0, 15, 1, "R6 control readback");
    doRead(1'b0, 14, 3, "R4 register burst");

    // write protect
    frame[1] = 8'hEE;
    doWrite(1'b1, 10, 1);
    doRead(1'b1, 10, 1, "R7 protected RAM unchanged");
    frame[1] = 8'h00;
    doWrite(1'b0, 15, 1);
    doRead(1'b0, 15, 1, "R7 control writable while protected");
    frame[1] = 8'h3C;
    doWrite(1'b1, 10, 1);
    doRead(1'b1, 10, 1, "R7 write after unprotect");

    // aborted bytes
    frame[0] = mkCmd(1'b0, 1'b1, 10, 1'b1);
    frame[1] = 8'hC3;
    runFrame(2, 5);
    doRead(1'b1, 10, 1, "R9 partial data byte discarded");
    frame[0] = mkCmd(1'b0, 1'b1, 12, 1'b1);
    frame[1] = 8'h99; frame[2] = 8'h66;
    runFrame(3, 3);
    mWrite(1'b1, 12, 8'h99);
    doRead(1'b1, 12, 2, "R9 completed byte kept, partial dropped");
    frame[0] = mkCmd(1'b1, 1'b1, 12, 1'b1);
    runFrame(1, 4);
    chk("R8 oe low after aborted command", {7'd0, doutEn}, 8'h00);
    doRead(1'b1, 12, 1, "R10 fresh command after abort");

    // constrained random traffic
    for (int t = 0; t < 70; t++) begin
      rd  = 1'($urandom % 2);
      ram = ($urandom % 4) != 0;
      if (ram) a = $urandom % 32;
      else     a = ($urandom % 3 == 0) ? $urandom % 32 : 15;
      n = 1 + $urandom % 6;
      if (rd) begin
        doRead(ram, a, n, "R3 random read");
      end else begin
        for (int i = 1; i <= n; i++) frame[i] = 8'($urandom);
        doWrite(ram, a, n);
      end
      chk("R8 oe low between frames", {7'd0, doutEn}, 8'h00);
    end

    doRead(1'b0, 15, 1, "R6 control after random");
    doRead(1'b1, 0, 32, "R3 final RAM sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule